// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block expands one column access request into the full series of column addresses for a read or write burst in a synchronous DRAM controller. A start strobe captures a 9-bit starting column together with the burst configuration. From the next cycle on, the block emits one column address per clock until the burst ends. A burst ends when the programmed length is reached, when a terminate request arrives, or when a new start replaces it.

The burst stays inside an aligned block whose size equals the burst length. Inside that block the addresses advance either by incrementing (sequential) or by XOR with a running count (interleaved). A full-page mode walks all 512 columns of the row, wrapping as needed, until it is told to stop. A per-request flag can force writes down to a single location while reads keep the programmed length. Length codes that are not defined fall back to a single access and raise an error flag.

Top module: `burst_col_seq`

## Requirements
- R1: While rst_ni is low and after its release, col_vld_o, done_o and len_err_o are 0 and col_o is 0.
- R2: A start_i sampled high at a clock edge makes col_vld_o high after that edge, with col_o equal to the captured start_col_i.
- R3: len_code_i selects the burst length: 3'b000 gives 1 address, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8. done_o is high together with the final address, and col_vld_o is low on the following cycle when no new start is given.
- R4: For lengths 2, 4 and 8, every address keeps the start column's bits above the low log2(length) bits. Only the low bits change, so the burst wraps within its aligned block.
- R5: With type_i = 0 (sequential), address k of the burst has low bits equal to (start low bits + k) modulo the length.
- R6: With type_i = 1 (interleaved), address k of the burst has low bits equal to (start low bits) XOR k.
- R7: len_code_i = 3'b111 with type_i = 0 is a full-page burst. Addresses increment modulo 512 with no end, done_o stays low, and the burst runs until a terminate.
- R8: term_i high in a cycle with col_vld_o high, and start_i low, makes col_vld_o low on the next cycle.
- R9: When single_wr_i = 1 and is_write_i = 1 at start, the burst has exactly one address. With is_write_i = 0 the programmed length applies unchanged.
- R10: start_i during an active burst abandons it. The next cycle shows the new start column, and the new burst then runs its own full sequence.
- R11: The codes 3'b100, 3'b101, 3'b110, and 3'b111 with type_i = 1, run as length 1. For these codes len_err_o is 1 from the cycle after the start until the next start; a defined code clears it.
- R12: Between the first and the final address, col_vld_o stays high every cycle and a new address appears on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new burst |
| start_col_i | input | 9 | Starting column |
| len_code_i | input | 3 | Burst length code |
| type_i | input | 1 | 0 sequential, 1 interleaved |
| single_wr_i | input | 1 | Force writes to a single location |
| is_write_i | input | 1 | 1 for a write burst |
| term_i | input | 1 | Stop the running burst |
| col_o | output | 9 | Current column address (0 when idle) |
| col_vld_o | output | 1 | col_o is a burst address |
| done_o | output | 1 | col_o is the final address of the burst |
| len_err_o | output | 1 | Last start used an undefined length code |

## Verification
Every output comes from a register loaded at the start edge, so the first address and the error flag appear one cycle after the start strobe. Address k follows k cycles later. The cycle after the final address, or after a terminate, shows col_vld_o low. The bench drives inputs on the falling edge and reads outputs on the falling edge after each rising edge. It therefore compares address k on the (k+1)-th falling edge after the start and checks the idle state one falling edge past the last address. Restart and terminate are applied on a falling edge where an address has just been checked, and their effect is read on the next one.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [2:0] {
    LEN_ONE   = 3'b000,
    LEN_TWO   = 3'b001,
    LEN_FOUR  = 3'b010,
    LEN_EIGHT = 3'b011,
    LEN_PAGE  = 3'b111
  } len_code_e;

  typedef enum logic {
    ORD_SEQ   = 1'b0,
    ORD_XOR   = 1'b1
  } order_e;
endpackage

// File: rtl/bsq_len_decode.sv
module bsq_len_decode
  import bsq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [2:0]       code_i,
  input  logic             order_i,
  input  logic             force_one_i,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o,
  output logic             err_o
);
  logic [COL_W-1:0] mask_raw;
  logic             page_raw;

  always_comb begin
    mask_raw = '0;
    page_raw = 1'b0;
    err_o    = 1'b0;
    case (code_i)
      LEN_ONE:   mask_raw = '0;
      LEN_TWO:   mask_raw = COL_W'(1);
      LEN_FOUR:  mask_raw = COL_W'(3);
      LEN_EIGHT: mask_raw = COL_W'(7);
      LEN_PAGE: begin
        if (order_i == ORD_XOR) err_o = 1'b1;
        else begin
          mask_raw = '1;
          page_raw = 1'b1;
        end
      end
      default:   err_o = 1'b1;
    endcase
  end

  assign mask_o = force_one_i ? '0 : mask_raw;
  assign page_o = force_one_i ? 1'b0 : page_raw;
endmodule

// File: rtl/bsq_ctrl.sv
module bsq_ctrl #(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             page_i,
  input  logic             order_i,
  input  logic             err_i,
  output logic             active_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] mask_o,
  output logic [COL_W-1:0] cnt_o,
  output logic             order_o,
  output logic             err_o,
  output logic             last_o
);
  logic             active_q, page_q, order_q, err_q;
  logic [COL_W-1:0] base_q, mask_q, cnt_q;

  assign last_o = active_q && !page_q && (cnt_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      page_q   <= 1'b0;
      order_q  <= 1'b0;
      err_q    <= 1'b0;
      base_q   <= '0;
      mask_q   <= '0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      page_q   <= page_i;
      order_q  <= order_i;
      err_q    <= err_i;
      base_q   <= col_i;
      mask_q   <= mask_i;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (term_i || last_o) active_q <= 1'b0;
      else                  cnt_q    <= cnt_q + COL_W'(1);
    end
  end

  assign active_o = active_q;
  assign base_o   = base_q;
  assign mask_o   = mask_q;
  assign cnt_o    = cnt_q;
  assign order_o  = order_q;
  assign err_o    = err_q;
endmodule

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic             order_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_off, xor_off, off;

  assign seq_off = base_i + cnt_i;
  assign xor_off = base_i ^ cnt_i;
  assign off     = order_i ? xor_off : seq_off;

  // Bits inside the block come from the offset, bits above from the start.
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? off[b] : base_i[b];
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             type_i,
  input  logic             single_wr_i,
  input  logic             is_write_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             col_vld_o,
  output logic             done_o,
  output logic             len_err_o
);
  logic [COL_W-1:0] dec_mask, base, mask, cnt, addr;
  logic             dec_page, dec_err, active, order;

  bsq_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i      (len_code_i),
    .order_i     (type_i),
    .force_one_i (single_wr_i & is_write_i),
    .mask_o      (dec_mask),
    .page_o      (dec_page),
    .err_o       (dec_err)
  );

  bsq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .term_i   (term_i),
    .col_i    (start_col_i),
    .mask_i   (dec_mask),
    .page_i   (dec_page),
    .order_i  (type_i),
    .err_i    (dec_err),
    .active_o (active),
    .base_o   (base),
    .mask_o   (mask),
    .cnt_o    (cnt),
    .order_o  (order),
    .err_o    (len_err_o),
    .last_o   (done_o)
  );

  bsq_addr_gen #(.COL_W(COL_W)) u_gen (
    .base_i  (base),
    .mask_i  (mask),
    .cnt_i   (cnt),
    .order_i (order),
    .col_o   (addr)
  );

  assign col_vld_o = active;
  assign col_o     = active ? addr : '0;
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int COL_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             single_wr_i,
  input logic             is_write_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             col_vld_o,
  input logic             done_o,
  input logic             len_err_o
);
  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !col_vld_o |-> (col_o == '0) && !done_o);

  assert_first_col_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> col_vld_o && (col_o == $past(start_col_i)));

  assert_done_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !col_vld_o);

  assert_term_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_vld_o && term_i && !start_i |=> !col_vld_o);

  assert_single_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && single_wr_i && is_write_i |=> done_o);

  assert_err_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(len_err_o));

  assert_no_gap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_vld_o && !done_o && !term_i |=> col_vld_o);
endmodule

bind burst_col_seq bsq_checker #(.COL_W(COL_W)) u_bsq_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .single_wr_i (single_wr_i),
  .is_write_i  (is_write_i),
  .term_i      (term_i),
  .col_o       (col_o),
  .col_vld_o   (col_vld_o),
  .done_o      (done_o),
  .len_err_o   (len_err_o)
);

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, typ = 1'b0, single = 1'b0, wr = 1'b0, term = 1'b0;
  logic [8:0] scol = '0;
  logic [2:0] code = '0;
  logic [8:0] col;
  logic       vld, done, err;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  burst_col_seq u_burst_col_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_col_i(scol),
    .len_code_i(code), .type_i(typ), .single_wr_i(single), .is_write_i(wr),
    .term_i(term), .col_o(col), .col_vld_o(vld), .done_o(done), .len_err_o(err)
  );

  typedef struct packed {
    logic [8:0] col;
    logic [2:0] code;
    logic       il;
    logic       wr;
    logic       single;
    logic [9:0] len;
    logic       err;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{9'd5,   3'b011, 1'b0, 1'b0, 1'b0, 10'd8, 1'b0},
    '{9'd5,   3'b011, 1'b1, 1'b0, 1'b0, 10'd8, 1'b0},
    '{9'd509, 3'b011, 1'b0, 1'b1, 1'b0, 10'd8, 1'b0},
    '{9'd3,   3'b010, 1'b0, 1'b0, 1'b0, 10'd4, 1'b0},
    '{9'd3,   3'b010, 1'b1, 1'b0, 1'b0, 10'd4, 1'b0},
    '{9'd255, 3'b010, 1'b1, 1'b0, 1'b0, 10'd4, 1'b0},
    '{9'd2,   3'b001, 1'b0, 1'b0, 1'b0, 10'd2, 1'b0},
    '{9'd1,   3'b001, 1'b1, 1'b0, 1'b0, 10'd2, 1'b0},
    '{9'd100, 3'b000, 1'b0, 1'b0, 1'b0, 10'd1, 1'b0},
    '{9'd6,   3'b011, 1'b1, 1'b1, 1'b1, 10'd1, 1'b0},
    '{9'd6,   3'b011, 1'b0, 1'b0, 1'b1, 10'd8, 1'b0},
    '{9'd4,   3'b100, 1'b0, 1'b0, 1'b0, 10'd1, 1'b1},
    '{9'd4,   3'b101, 1'b1, 1'b0, 1'b0, 10'd1, 1'b1},
    '{9'd77,  3'b110, 1'b0, 1'b0, 1'b0, 10'd1, 1'b1},
    '{9'd12,  3'b111, 1'b1, 1'b0, 1'b0, 10'd1, 1'b1},
    '{9'd330, 3'b011, 1'b1, 1'b0, 1'b0, 10'd8, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference: aligned block of size len, offset walks by add or by XOR.
  function automatic int ref_col(input int s, input int len, input logic il, input int k);
    int blk = (s / len) * len;
    int off = s % len;
    return blk + (il ? (off ^ k) : ((off + k) % len));
  endfunction

  task automatic launch(input logic [8:0] c, input logic [2:0] lc, input logic il,
                        input logic w, input logic sg);
    scol = c; code = lc; typ = il; wr = w; single = sg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    launch(v.col, v.code, v.il, v.wr, v.single);
    chk("R11 err flag", int'(err), int'(v.err));
    for (int k = 0; k < int'(v.len); k++) begin
      chk("R12 valid", int'(vld), 1);
      chk(v.il ? "R6 interleaved col" : "R5 sequential col", int'(col),
          ref_col(int'(v.col), int'(v.len), v.il, k));
      chk("R4 block upper bits", int'(col) / int'(v.len), int'(v.col) / int'(v.len));
      chk("R3 done on last", int'(done), (k == int'(v.len) - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk("R3 idle after last", int'(vld), 0);
    chk("R11 err held", int'(err), int'(v.err));
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset vld", int'(vld), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset err", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release vld", int'(vld), 0);
    chk("R1 after release col", int'(col), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R7: full page from 500, run past the page wrap, then terminate (R8)
    launch(9'd500, 3'b111, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 600; k++) begin
      chk("R7 page col", int'(col), (500 + k) % 512);
      chk("R7 page no done", int'(done), 0);
      if (k == 599) term = 1'b1;
      @(negedge clk);
    end
    term = 1'b0;
    chk("R8 page stops on term", int'(vld), 0);
    @(negedge clk);

    // R8: terminate an 8-burst at its third address
    launch(9'd16, 3'b011, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      chk("R8 col before term", int'(col), 16 + k);
      if (k == 2) term = 1'b1;
      @(negedge clk);
    end
    term = 1'b0;
    chk("R8 stopped", int'(vld), 0);
    @(negedge clk);

    // R9: same config as a read runs full length
    launch(9'd40, 3'b010, 1'b0, 1'b0, 1'b1);
    chk("R9 read not forced", int'(done), 0);
    repeat (4) @(negedge clk);

    // R10: restart at the fourth address of an interleaved 8-burst
    launch(9'd8, 3'b011, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      chk("R10 old burst col", int'(col), ref_col(8, 8, 1'b1, k));
      if (k < 3) @(negedge clk);
    end
    launch(9'd201, 3'b010, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      chk("R10 new burst col", int'(col), ref_col(201, 4, 1'b0, k));
      chk("R10 new burst done", int'(done), (k == 3) ? 1 : 0);
      @(negedge clk);
    end
    chk("R10 idle", int'(vld), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule